// File: doc/BRIEF.md
# Ping-Pong Transpose Buffer

This block sits between the row pass and the column pass of an 8x8 two-dimensional transform. It accepts a stream of 11-bit intermediate coefficients, one word per clock while the input valid is high, in row-major order: row 0 columns 0 to 7, then row 1, and so on up to row 7. It hands each completed block back in column-major order, so the second pass sees the block already transposed.

Storage is two 64-word banks. While one bank fills with the incoming block, the other bank drains the previous block. The roles swap every 64 accepted words, so a continuous input stream gives a continuous output stream with no gap between blocks. The output is paced by the input: each accepted word of block n+1 releases one word of block n. A stall on the input therefore pauses both sides together.

A sticky enable tells the second pass that the first bank is full and column-ordered data is now flowing. A first-word flag marks the start of every output block.

Top module: `transpose_pingpong`

## Requirements
- R1: While reset is high and after it is released, outValid, outFirst and passEn are 0 and outData is 0 until the first output word.
- R2: A word is stored only at a rising edge where inValid is 1. inData is ignored whenever inValid is 0. Accepted words fill a 64-word block in row-major order, where word index = 8*row + column.
- R3: passEn rises at the edge that accepts the 64th word after reset and stays 1 until reset.
- R4: No output word appears while passEn is 0.
- R5: While passEn is 1, outValid is 1 in the cycle after each edge where inValid was 1, and 0 in the cycle after each edge where inValid was 0.
- R6: Output word j of a block is the input word with index 8*(j mod 8) + (j div 8), which is column-major order.
- R7: outFirst is 1 together with output word 0 of every block, and 0 on every other cycle.
- R8: Block n is read out while block n+1 is written, with the two banks swapping roles every 64 accepted words. Back-to-back blocks leave no idle cycle on the output.
- R9: Output word j of block n appears one cycle after the edge that accepts word j of block n+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| inValid | input | 1 | Input word present this cycle |
| inData | input | 11 | Row-ordered intermediate coefficient |
| passEn | output | 1 | Sticky enable for the second pass, set once the first bank is full |
| outValid | output | 1 | outData carries a column-ordered word |
| outFirst | output | 1 | First word of an output block |
| outData | output | 11 | Column-ordered coefficient, registered |

## Verification
A wrong bank select would show up at the ports as words from the block being written, or from the block two positions back. This is visible on the first output word after the faulty swap. A wrong read address shows a row-ordered or scrambled word within one cycle of the error. A miscounted write counter shifts passEn and outFirst off their 64-word boundaries, and the flags expose this at the next block edge. Irregular stalls check that both counters pause together, because any drift corrupts the next word read.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
  parameter int SIDE_LOG2 = 3;
  localparam int ADDR_W = 2 * SIDE_LOG2;
  localparam int DEPTH = 1 << ADDR_W;

  typedef struct packed {
    logic              wrEn;
    logic              wrBank;
    logic [ADDR_W-1:0] wrAddr;
    logic              rdEn;
    logic              rdBank;
    logic [ADDR_W-1:0] rdAddr;
    logic              rdFirst;
  } tpb_strobes_t;
endpackage

// File: rtl/tpb_ctrl.sv
module tpb_ctrl
  import tpb_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output tpb_strobes_t strobes,
  output logic         passEn
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] wrCnt;
  logic [ADDR_W-1:0] rdCnt;
  logic              bankSel;
  logic              armed;

  // The write counter wraps to flip the banks; the read counter runs only once a bank is full.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wrCnt   <= '0;
      rdCnt   <= '0;
      bankSel <= 1'b0;
      armed   <= 1'b0;
    end else if (inValid) begin
      wrCnt <= wrCnt + 1'b1;
      if (wrCnt == LAST) begin
        bankSel <= ~bankSel;
        armed   <= 1'b1;
      end
      if (armed) rdCnt <= rdCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.wrEn    = inValid;
    strobes.wrBank  = bankSel;
    strobes.wrAddr  = wrCnt;
    strobes.rdEn    = inValid && armed;
    strobes.rdBank  = ~bankSel;
    // Swapping the row and column fields gives the transposed read address.
    strobes.rdAddr  = {rdCnt[SIDE_LOG2-1:0], rdCnt[ADDR_W-1:SIDE_LOG2]};
    strobes.rdFirst = (rdCnt == '0);
  end

  assign passEn = armed;
endmodule

// File: rtl/tpb_datapath.sv
module tpb_datapath
  import tpb_pkg::*;
#(
  parameter int DATA_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  tpb_strobes_t      strobes,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic              outFirst,
  output logic [DATA_W-1:0] outData
);
  logic [DATA_W-1:0] bankRd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobes.wrEn && (strobes.wrBank == 1'(b))) mem[strobes.wrAddr] <= inData;
    end

    assign bankRd[b] = mem[strobes.rdAddr];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      outValid <= 1'b0;
      outFirst <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strobes.rdEn;
      outFirst <= strobes.rdEn && strobes.rdFirst;
      if (strobes.rdEn) outData <= bankRd[strobes.rdBank];
    end
  end
endmodule

// File: rtl/transpose_pingpong.sv
module transpose_pingpong
  import tpb_pkg::*;
#(
  parameter int DATA_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              passEn,
  output logic              outValid,
  output logic              outFirst,
  output logic [DATA_W-1:0] outData
);
  tpb_strobes_t strobes;

  tpb_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobes (strobes),
    .passEn  (passEn)
  );

  tpb_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .inData   (inData),
    .outValid (outValid),
    .outFirst (outFirst),
    .outData  (outData)
  );
endmodule

// File: rtl/tpb_checker.sv
module tpb_checker
  import tpb_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic inValid,
  input logic passEn,
  input logic outValid,
  input logic outFirst
);
  logic [ADDR_W-1:0] outCnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) outCnt <= '0;
    else if (outValid) outCnt <= outCnt + 1'b1;
  end

  a_r3_enable_sticky: assert property (@(posedge clk) disable iff (rst)
    passEn |=> passEn);

  a_r3_rise_on_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(passEn) |-> $past(inValid));

  a_r4_silent_before_full: assert property (@(posedge clk) disable iff (rst)
    !passEn |-> !outValid);

  a_r5_valid_follows_input: assert property (@(posedge clk) disable iff (rst)
    (inValid && passEn) |=> outValid);

  a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  a_r7_first_on_boundary: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outFirst == (outCnt == '0)));

  a_r7_first_needs_valid: assert property (@(posedge clk) disable iff (rst)
    outFirst |-> outValid);
endmodule

bind transpose_pingpong tpb_checker chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .passEn   (passEn),
  .outValid (outValid),
  .outFirst (outFirst)
);

// File: tb/transpose_pingpong_test.sv
`timescale 1ns/1ps
module transpose_pingpong_test;
  localparam int W = 11;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [W-1:0] inData = '0;
  logic         passEn, outValid, outFirst;
  logic [W-1:0] outData;

  int errors = 0;
  int checks = 0;
  int accepted = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  transpose_pingpong uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .passEn(passEn), .outValid(outValid), .outFirst(outFirst), .outData(outData)
  );

  function automatic logic [W-1:0] wordVal(input int blk, input int idx);
    return W'((blk * 64 + idx) * 29 + 7);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (word %0d)", req, act, exp, accepted);
    end
  endtask

  // Runs n cycles; in gap mode inValid drops on a fixed pattern and garbage drives inData (R2).
  task automatic runCycles(input int n, input bit gaps);
    for (int c = 0; c < n; c++) begin
      bit v;
      int blk, j;
      @(negedge clk);
      v = !(gaps && ((c % 7) == 3 || (c % 11) == 5));
      blk = accepted / 64;
      j = accepted % 64;
      inValid = v;
      inData = v ? wordVal(blk, j) : W'(11'h7FF ^ c);
      @(posedge clk);
      #1;
      if (v) begin
        check("R3 passEn", passEn, (accepted + 1) >= 64);
        check("R5/R4 outValid", outValid, accepted >= 64);
        check("R7 outFirst", outFirst, (accepted >= 64) && (j == 0));
        if (accepted >= 64)
          check("R6/R8/R9 outData", outData, wordVal(blk - 1, (j % 8) * 8 + j / 8));
        accepted++;
      end else begin
        check("R5 outValid idle", outValid, 0);
        check("R7 outFirst idle", outFirst, 0);
        check("R3 passEn hold", passEn, accepted >= 64);
      end
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    #1;
    check("R1 reset passEn", passEn, 0);
    check("R1 reset outValid", outValid, 0);
    check("R1 reset outFirst", outFirst, 0);
    check("R1 reset outData", outData, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    accepted = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset passEn", passEn, 0);
    check("R1 reset outValid", outValid, 0);
    rst = 1'b0;
    runCycles(256, 1'b0);   // four back-to-back blocks
    runCycles(300, 1'b1);   // stalls in both filling and draining
    runCycles(70, 1'b0);
    doReset();
    runCycles(140, 1'b1);   // after reset the banks restart from the first bank
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule